// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a running nanosecond time-of-day value for precision time protocol use. A wide accumulator has 64 whole-nanosecond bits and 32 fraction bits. On every core clock cycle while counting is enabled, a software-programmed increment is added to it. The increment is held in 32.32 fixed point: whole nanoseconds per cycle in the upper half and fractions of a nanosecond in the lower half. For example, a 800 MHz core clock gives a nominal increment of 1.25 ns, which is 0x1_4000_0000. Software trims the frequency at run time by rewriting the increment, and the counter does not stop while it does so.

The host reaches the block through a flat 64-bit register port with a write strobe, a read strobe and a byte address. Read data is combinational on the address. The port holds four registers: a configuration word carrying the enable, the increment, and the whole-nanosecond and fraction views of the time. A read strobe on the whole-nanosecond word captures the fraction at the same instant. A later fraction read therefore returns a value that is coherent with the whole-nanosecond value already read.

Top module: `frac_tod_counter`

## Requirements
- R1: After reset the time, the enable, the increment and the captured fraction are all zero, so every defined register reads zero.
- R2: While enabled, and in a cycle with no write to a time word, the 96-bit time (64 integer bits above 32 fraction bits) grows by the 64-bit increment on each clock edge. Fraction overflow carries into the integer bits.
- R3: While the enable is clear, the time holds its value.
- R4: The configuration word at offset 0xF00 holds the enable in bit 0. A write sets the enable from wdata bit 0. A read returns the enable in bit 0 and zeros in all other bits.
- R5: The increment at offset 0xF18 stores all 64 written bits and reads them back. A value written at one edge is the amount added at the following edge.
- R6: A read of offset 0xF10 returns the 64 integer bits of the time (accumulator bits 95:32).
- R7: A read of offset 0xF08 returns, in bits 31:0, the fraction captured by the most recent read strobe at 0xF10, and zeros above. The captured value changes only on such a strobe.
- R8: A write to 0xF10 loads the integer bits from wdata. A write to 0xF08 loads the fraction from wdata bits 31:0. In that cycle no increment is applied and the other part keeps its value.
- R9: The time wraps modulo 2^96.
- R10: Writes to any other offset change nothing, and reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (captures the fraction on a 0xF10 read) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, combinational on reg_addr |

## Verification
On every cycle, the assertions check the per-edge step of the accumulator, its hold while disabled, direct loads of the time words, next-edge capture of the increment, zero read data at undefined offsets and the stability of the captured fraction. Only the bench's scenarios can show end-to-end behaviour: a trimmed increment changing the count from the next edge, fraction carries into whole nanoseconds, wrap of the full 96-bit value, and fraction coherence across a whole/fraction read pair. The bench compares the read data against its reference model on every clock.

// File: rtl/frac_tod_pkg.sv
package frac_tod_pkg;
   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_CFG  = 3'd1,
      SEL_FRAC = 3'd2,
      SEL_INT  = 3'd3,
      SEL_INC  = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/frac_tod_decode.sv
module frac_tod_decode
   import frac_tod_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] OFS_CFG  = 'hF00,
   parameter logic [ADDR_W-1:0] OFS_FRAC = 'hF08,
   parameter logic [ADDR_W-1:0] OFS_INT  = 'hF10,
   parameter logic [ADDR_W-1:0] OFS_INC  = 'hF18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel,
   output logic              wr_cfg,
   output logic              wr_inc,
   output logic              wr_int,
   output logic              wr_frac,
   output logic              rd_int
);
   generate
      if (OFS_CFG == OFS_FRAC || OFS_CFG == OFS_INT || OFS_CFG == OFS_INC ||
          OFS_FRAC == OFS_INT || OFS_FRAC == OFS_INC || OFS_INT == OFS_INC) begin : g_bad_map
         $error("frac_tod_decode: register offsets must be distinct");
      end
   endgenerate

   always_comb begin
      if (addr == OFS_CFG)       sel = SEL_CFG;
      else if (addr == OFS_FRAC) sel = SEL_FRAC;
      else if (addr == OFS_INT)  sel = SEL_INT;
      else if (addr == OFS_INC)  sel = SEL_INC;
      else                       sel = SEL_NONE;
   end

   assign wr_cfg  = wr && (sel == SEL_CFG);
   assign wr_inc  = wr && (sel == SEL_INC);
   assign wr_int  = wr && (sel == SEL_INT);
   assign wr_frac = wr && (sel == SEL_FRAC);
   assign rd_int  = rd && (sel == SEL_INT);

   // R10: at most one register is written per cycle, none for undefined offsets
   p_one_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_cfg, wr_inc, wr_int, wr_frac}));
   p_undef_nowr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != OFS_CFG && addr != OFS_FRAC && addr != OFS_INT && addr != OFS_INC)
      |-> !(wr_cfg || wr_inc || wr_int || wr_frac));
endmodule

// File: rtl/frac_tod_accum.sv
module frac_tod_accum #(
   parameter int INT_W  = 64,
   parameter int FRAC_W = 32,
   parameter int INC_W  = 64,
   parameter int SEG_W  = 32,
   localparam int TOT_W   = INT_W + FRAC_W,
   localparam int NUM_SEG = TOT_W / SEG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [INC_W-1:0]  inc,
   input  logic              ld_int,
   input  logic [INT_W-1:0]  ld_int_val,
   input  logic              ld_frac,
   input  logic [FRAC_W-1:0] ld_frac_val,
   output logic [TOT_W-1:0]  acc
);
   generate
      if (TOT_W % SEG_W != 0) begin : g_bad_seg
         $error("frac_tod_accum: SEG_W must divide INT_W+FRAC_W");
      end
      if (INC_W > TOT_W) begin : g_bad_inc
         $error("frac_tod_accum: increment wider than accumulator");
      end
   endgenerate

   logic [TOT_W-1:0]  acc_q;
   logic [TOT_W-1:0]  inc_ext;
   logic [TOT_W-1:0]  sum;
   logic [NUM_SEG-1:0] cy;

   assign inc_ext = TOT_W'(inc);
   assign cy[0]   = 1'b0;

   // Segmented carry chain; the last segment drops its carry (modulo 2^TOT_W)
   generate
      for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
         if (g < NUM_SEG - 1) begin : g_mid
            assign {cy[g+1], sum[g*SEG_W +: SEG_W]} =
               {1'b0, acc_q[g*SEG_W +: SEG_W]} + {1'b0, inc_ext[g*SEG_W +: SEG_W]}
               + (SEG_W+1)'(cy[g]);
         end else begin : g_top
            assign sum[g*SEG_W +: SEG_W] =
               acc_q[g*SEG_W +: SEG_W] + inc_ext[g*SEG_W +: SEG_W] + SEG_W'(cy[g]);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (ld_int || ld_frac) begin
         if (ld_int)  acc_q[TOT_W-1:FRAC_W] <= ld_int_val;
         if (ld_frac) acc_q[FRAC_W-1:0]     <= ld_frac_val;
      end else if (run) begin
         acc_q <= sum;
      end
   end

   assign acc = acc_q;

   // R2/R9: one step per enabled edge, modulo 2^TOT_W
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ld_int && !ld_frac) |=> acc_q == TOT_W'($past(acc_q) + $past(inc_ext)));
   // R3: disabled means hold
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ld_int && !ld_frac) |=> $stable(acc_q));
   // R8: direct loads take priority and leave the other part untouched
   p_load_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_int && !ld_frac) |=> (acc_q[TOT_W-1:FRAC_W] == $past(ld_int_val))
                               && (acc_q[FRAC_W-1:0] == $past(acc_q[FRAC_W-1:0])));
   p_load_frac_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_frac && !ld_int) |=> (acc_q[FRAC_W-1:0] == $past(ld_frac_val))
                               && (acc_q[TOT_W-1:FRAC_W] == $past(acc_q[TOT_W-1:FRAC_W])));
endmodule

// File: rtl/frac_tod_snap.sv
module frac_tod_snap #(
   parameter int FRAC_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [FRAC_W-1:0] frac_in,
   output logic [FRAC_W-1:0] frac_out
);
   logic [FRAC_W-1:0] snap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   snap_q <= '0;
      else if (cap) snap_q <= frac_in;
   end

   assign frac_out = snap_q;

   // R7: the captured fraction only moves on a capture strobe
   p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(snap_q));
   p_snap_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> snap_q == $past(frac_in));
endmodule

// File: rtl/frac_tod_counter.sv
module frac_tod_counter
   import frac_tod_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 64,
   parameter int INT_W  = 64,
   parameter int FRAC_W = 32,
   parameter int SEG_W  = 32,
   parameter logic [ADDR_W-1:0] OFS_CFG  = 'hF00,
   parameter logic [ADDR_W-1:0] OFS_FRAC = 'hF08,
   parameter logic [ADDR_W-1:0] OFS_INT  = 'hF10,
   parameter logic [ADDR_W-1:0] OFS_INC  = 'hF18,
   localparam int TOT_W = INT_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);
   generate
      if (INT_W > DATA_W || FRAC_W > DATA_W) begin : g_bad_width
         $error("frac_tod_counter: time words must fit the data width");
      end
   endgenerate

   reg_sel_e          sel;
   logic              wr_cfg, wr_inc, wr_int, wr_frac, rd_int;
   logic              run_q;
   logic [DATA_W-1:0] inc_q;
   logic [TOT_W-1:0]  acc;
   logic [FRAC_W-1:0] snap;

   frac_tod_decode #(
      .ADDR_W(ADDR_W), .OFS_CFG(OFS_CFG), .OFS_FRAC(OFS_FRAC),
      .OFS_INT(OFS_INT), .OFS_INC(OFS_INC)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
      .sel(sel), .wr_cfg(wr_cfg), .wr_inc(wr_inc), .wr_int(wr_int),
      .wr_frac(wr_frac), .rd_int(rd_int)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         inc_q <= '0;
      end else begin
         if (wr_cfg) run_q <= reg_wdata[0];
         if (wr_inc) inc_q <= reg_wdata;
      end
   end

   frac_tod_accum #(
      .INT_W(INT_W), .FRAC_W(FRAC_W), .INC_W(DATA_W), .SEG_W(SEG_W)
   ) u_accum (
      .clk(clk), .rst_n(rst_n), .run(run_q), .inc(inc_q),
      .ld_int(wr_int), .ld_int_val(reg_wdata[INT_W-1:0]),
      .ld_frac(wr_frac), .ld_frac_val(reg_wdata[FRAC_W-1:0]),
      .acc(acc)
   );

   frac_tod_snap #(.FRAC_W(FRAC_W)) u_snap (
      .clk(clk), .rst_n(rst_n), .cap(rd_int),
      .frac_in(acc[FRAC_W-1:0]), .frac_out(snap)
   );

   always_comb begin
      unique case (sel)
         SEL_CFG:  reg_rdata = DATA_W'(run_q);
         SEL_FRAC: reg_rdata = DATA_W'(snap);
         SEL_INT:  reg_rdata = DATA_W'(acc[TOT_W-1:FRAC_W]);
         SEL_INC:  reg_rdata = inc_q;
         default:  reg_rdata = '0;
      endcase
   end

   // R5: the increment register captures the written word at that edge
   p_inc_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_inc |=> inc_q == $past(reg_wdata));
   // R4: enable follows wdata bit 0 of a configuration write
   p_cfg_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cfg |=> run_q == $past(reg_wdata[0]));
   p_cfg_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == OFS_CFG) |-> reg_rdata[DATA_W-1:1] == '0);
   // R10: undefined offsets read zero
   p_undef_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr != OFS_CFG && reg_addr != OFS_FRAC && reg_addr != OFS_INT &&
       reg_addr != OFS_INC) |-> reg_rdata == '0);
endmodule

// File: tb/frac_tod_counter_bench.sv
module frac_tod_counter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   frac_tod_counter u_frac_tod_counter (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   // reference model
   logic [95:0] m_time = '0;
   logic [63:0] m_inc  = '0;
   bit          m_on   = 0;
   logic [31:0] m_snap = '0;

   function automatic logic [63:0] exp_read(input logic [11:0] a);
      case (a)
         12'hF00: return {63'd0, m_on};
         12'hF08: return {32'd0, m_snap};
         12'hF10: return m_time[95:32];
         12'hF18: return m_inc;
         default: return 64'd0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_time = '0; m_inc = '0; m_on = 0; m_snap = '0;
      end else begin
         logic [95:0] t_old;
         bit          on_old;
         logic [63:0] inc_old;
         bit          loaded;
         t_old = m_time; on_old = m_on; inc_old = m_inc; loaded = 0;
         if (reg_rd && reg_addr == 12'hF10) m_snap = t_old[31:0];
         if (reg_wr) begin
            case (reg_addr)
               12'hF00: m_on = reg_wdata[0];
               12'hF18: m_inc = reg_wdata;
               12'hF10: begin m_time[95:32] = reg_wdata; loaded = 1; end
               12'hF08: begin m_time[31:0] = reg_wdata[31:0]; loaded = 1; end
               default: ;
            endcase
         end
         if (!loaded && on_old) m_time = t_old + {32'd0, inc_old};
      end
   end

   task automatic cyc(input bit w, input bit r, input logic [11:0] a,
                      input logic [63:0] d, input string tag);
      @(negedge clk);
      reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
      #1;
      n_run++;
      if (reg_rdata !== exp_read(a)) begin
         n_fail++;
         $display("FAIL %s addr=%h rdata=%h expected=%h", tag, a, reg_rdata, exp_read(a));
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired rdata=%h expected=finish", reg_rdata);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      cyc(0, 0, 12'hF00, 0, "R1");
      cyc(0, 0, 12'hF18, 0, "R1");
      @(negedge clk); rst_n = 1'b1;
      cyc(0, 0, 12'hF10, 0, "R1");
      cyc(0, 0, 12'hF08, 0, "R1");
      cyc(0, 0, 12'hF18, 0, "R1");
      cyc(0, 0, 12'hF00, 0, "R1");
      // R5: increment programming
      cyc(1, 0, 12'hF18, 64'h1_4000_0000, "R5");
      cyc(0, 0, 12'hF18, 0, "R5");
      // R4: enable
      cyc(1, 0, 12'hF00, 64'h1, "R4");
      cyc(0, 0, 12'hF00, 0, "R4");
      // R2, R6, R7: counting with coherent reads
      for (int i = 0; i < 10; i++) cyc(0, 1, 12'hF10, 0, "R6");
      cyc(0, 0, 12'hF08, 0, "R7");
      cyc(0, 0, 12'hF10, 0, "R2");
      cyc(0, 0, 12'hF08, 0, "R7");
      // R5: trim while running, effective next edge
      cyc(1, 0, 12'hF18, 64'h0000_0000_C000_0001, "R5");
      for (int i = 0; i < 8; i++) cyc(0, 1, 12'hF10, 0, "R5");
      cyc(0, 0, 12'hF08, 0, "R7");
      // R3: disable and hold
      cyc(1, 0, 12'hF00, 64'h0, "R3");
      for (int i = 0; i < 5; i++) cyc(0, 0, 12'hF10, 0, "R3");
      cyc(1, 0, 12'hF00, 64'hFFFF_FFFF_FFFF_FFFE, "R4");
      cyc(0, 0, 12'hF00, 0, "R4");
      cyc(0, 0, 12'hF10, 0, "R3");
      // R8: direct loads
      cyc(1, 0, 12'hF10, 64'hFFFF_FFFF_FFFF_FFFE, "R8");
      cyc(1, 0, 12'hF08, 64'hAAAA_BBBB_F000_0000, "R8");
      cyc(0, 1, 12'hF10, 0, "R6");
      cyc(0, 0, 12'hF08, 0, "R7");
      // R9: wrap of the full 96-bit value
      cyc(1, 0, 12'hF18, 64'h1_2000_0000, "R9");
      cyc(1, 0, 12'hF00, 64'h1, "R9");
      for (int i = 0; i < 4; i++) cyc(0, 1, 12'hF10, 0, "R9");
      cyc(0, 0, 12'hF08, 0, "R9");
      // R8: load while running takes priority over the step
      cyc(1, 0, 12'hF10, 64'h5, "R8");
      cyc(0, 1, 12'hF10, 0, "R8");
      cyc(1, 0, 12'hF08, 64'h1234, "R8");
      cyc(0, 1, 12'hF10, 0, "R8");
      cyc(0, 0, 12'hF08, 0, "R8");
      // R10: undefined offsets
      cyc(1, 0, 12'hF20, 64'hDEAD_BEEF_0000_0001, "R10");
      cyc(1, 1, 12'hF04, 64'hFFFF_FFFF_FFFF_FFFF, "R10");
      cyc(1, 0, 12'h000, 64'h0, "R10");
      cyc(0, 0, 12'hFF8, 0, "R10");
      cyc(0, 0, 12'hF18, 0, "R10");
      cyc(0, 0, 12'hF00, 0, "R10");
      cyc(0, 0, 12'hF08, 0, "R10");
      cyc(0, 1, 12'hF10, 0, "R10");
      // R7: fraction read without a new strobe keeps the old capture
      for (int i = 0; i < 3; i++) cyc(0, 0, 12'hF08, 0, "R7");
      // R1: reset mid-run clears everything
      @(negedge clk); rst_n = 1'b0;
      cyc(0, 0, 12'hF10, 0, "R1");
      @(negedge clk); rst_n = 1'b1;
      cyc(0, 0, 12'hF18, 0, "R1");
      cyc(0, 0, 12'hF10, 0, "R1");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule